// File: doc/BRIEF.md
# Pointer Index Update Unit (Reverse-Carry and Wrap-Around)

This unit produces the value an address-pointer register holds after an access. The 32-bit register is split into two halves. The low half is a running index. The high half is a fixed parameter that the unit never changes. The unit has two modes.

In reverse-carry mode, the high half is an increment. It is added to the index with the carry travelling from bit 15 down toward bit 0, which is the stepping order that FFT butterflies need. In wrap-around mode, the high half is a buffer length. A small signed step is added to the index, and the result is folded back into the range 0 to length-1, whichever way it left that range.

The result is registered. It appears one cycle after a valid input, together with its own valid flag. Base address, memory access and instruction decode belong to the surrounding pipeline.

Top module: `ptr_index_update`

## Requirements
- R1: With `mode_i` = 0 (reverse-carry), the new index is the 16-bit bit reversal of (bitrev(index) + bitrev(increment)). Here index is `reg_i[15:0]` and increment is `reg_i[31:16]`. The carry therefore moves from bit 15 toward bit 0, and `step_i` has no effect in this mode.
- R2: In reverse-carry mode, a carry leaving bit 0 (the top of the reversed sum) is dropped. For example, index 0xFFFF with increment 0x8000 gives 0x0000.
- R3: With `mode_i` = 1 (wrap-around), `step_i` is a 10-bit two's-complement value. It is sign-extended and added to index `reg_i[15:0]`. If the sum is non-negative and not below the length `reg_i[31:16]`, the length is subtracted once.
- R4: In wrap-around mode, a negative sum has the length added to it once.
- R5: In wrap-around mode, a length of zero leaves the index unchanged whatever the step.
- R6: In both modes, output bits 31:16 equal input bits 31:16, and only bits 15:0 are replaced.
- R7: `out_valid_o` is `in_valid_i` delayed by one clock. `out_reg_o` is loaded only on a cycle with `in_valid_i` high and otherwise holds its value.
- R8: While `rst_n` is low, `out_valid_o` and `out_reg_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input strobe |
| mode_i | input | 1 | 0 reverse-carry, 1 wrap-around |
| reg_i | input | 32 | Current pointer register {parameter, index} |
| step_i | input | 10 | Signed step, used in wrap-around mode |
| out_valid_o | output | 1 | Result strobe, one cycle after input |
| out_reg_o | output | 32 | Updated pointer register |

## Verification
Reverse-carry mode is driven through a full 8-point sequence with increment 0x0004 and through single steps with increment 0x8000. This shows whether the carry moves downward rather than upward, and whether it is dropped past bit 0. An increment with two bits set and a set bit in the index outside the stepped field show that the unused bits are kept.

Wrap-around mode is tried with:
- sums inside the buffer;
- sums exactly at the length;
- sums one below zero;
- the extreme steps -512 and +511;
- zero length.

These cases separate the upward fold, the downward fold and the no-divide guard.

The same register value is also run through both modes, which shows that mode selection works.

// File: rtl/ptr_index_update.sv
module ptr_index_update #(
  parameter int HALF_W = 16,
  parameter int STEP_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid_i,
  input  logic                  mode_i,
  input  logic [2*HALF_W-1:0]   reg_i,
  input  logic [STEP_W-1:0]     step_i,
  output logic                  out_valid_o,
  output logic [2*HALF_W-1:0]   out_reg_o
);
  localparam int SUM_W = HALF_W + 2;

  logic [HALF_W-1:0] idx, hi;
  assign idx = reg_i[HALF_W-1:0];
  assign hi  = reg_i[2*HALF_W-1:HALF_W];

  // reverse-carry path
  logic [HALF_W-1:0] idx_rev, inc_rev, sum_rev, rc_idx;
  for (genvar g = 0; g < HALF_W; g++) begin : g_rev
    assign idx_rev[g] = idx[HALF_W-1-g];
    assign inc_rev[g] = hi[HALF_W-1-g];
    assign rc_idx[g]  = sum_rev[HALF_W-1-g];
  end
  assign sum_rev = idx_rev + inc_rev;

  // wrap-around path
  logic signed [SUM_W-1:0] step_x, raw, len_x;
  logic [HALF_W-1:0] wr_idx;
  assign step_x = {{(SUM_W-STEP_W){step_i[STEP_W-1]}}, step_i};
  assign len_x  = {2'b00, hi};
  assign raw    = $signed({2'b00, idx}) + step_x;

  always_comb begin
    if (hi == '0)             wr_idx = idx;
    else if (raw < 0)         wr_idx = HALF_W'(raw + len_x);
    else if (raw >= len_x)    wr_idx = HALF_W'(raw - len_x);
    else                      wr_idx = HALF_W'(raw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_reg_o   <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_reg_o <= {hi, mode_i ? wr_idx : rc_idx};
    end
  end

  // checks
  logic [HALF_W-1:0] step_mag;
  assign step_mag = step_i[STEP_W-1] ? HALF_W'(-step_x) : HALF_W'(step_x);

  assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_reg_o[2*HALF_W-1:HALF_W] == $past(reg_i[2*HALF_W-1:HALF_W]));

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid_o == $past(in_valid_i));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> $stable(out_reg_o));

  assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && mode_i && hi == '0) |=> out_reg_o[HALF_W-1:0] == $past(reg_i[HALF_W-1:0]));

  assert_in_buffer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && mode_i && hi != '0 && idx < hi && step_mag < hi)
    |=> out_reg_o[HALF_W-1:0] < $past(reg_i[2*HALF_W-1:HALF_W]));

  assert_zero_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !mode_i && hi == '0) |=> out_reg_o[HALF_W-1:0] == $past(reg_i[HALF_W-1:0]));
endmodule

// File: tb/test_ptr_index_update.sv
`timescale 1ns/1ps
module test_ptr_index_update;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid_i = 1'b0, mode_i = 1'b0;
  logic [31:0] reg_i = '0;
  logic [9:0]  step_i = '0;
  logic out_valid_o;
  logic [31:0] out_reg_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptr_index_update i_ptr_index_update (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .mode_i(mode_i),
    .reg_i(reg_i), .step_i(step_i), .out_valid_o(out_valid_o), .out_reg_o(out_reg_o));

  // {req, mode, reg, step, expected}
  localparam int NV = 22;
  localparam logic [78:0] VEC [NV] = '{
    {4'd1, 1'b0, 32'h8000_0000, 10'h000, 32'h8000_8000},  // R1
    {4'd1, 1'b0, 32'h8000_8000, 10'h000, 32'h8000_4000},  // R1
    {4'd1, 1'b0, 32'h8000_C000, 10'h000, 32'h8000_2000},  // R1
    {4'd2, 1'b0, 32'h8000_FFFF, 10'h000, 32'h8000_0000},  // R2
    {4'd1, 1'b0, 32'h0004_0000, 10'h000, 32'h0004_0004},  // R1
    {4'd1, 1'b0, 32'h0004_0004, 10'h000, 32'h0004_0002},  // R1
    {4'd1, 1'b0, 32'h0004_0006, 10'h000, 32'h0004_0001},  // R1
    {4'd2, 1'b0, 32'h0004_0007, 10'h000, 32'h0004_0000},  // R2
    {4'd1, 1'b0, 32'h0004_0104, 10'h000, 32'h0004_0102},  // R1
    {4'd1, 1'b0, 32'h0006_0002, 10'h000, 32'h0006_0005},  // R1
    {4'd1, 1'b0, 32'h0000_1234, 10'h155, 32'h0000_1234},  // R1 step ignored
    {4'd3, 1'b1, 32'h0064_000A, 10'h005, 32'h0064_000F},  // R3
    {4'd3, 1'b1, 32'h0064_005E, 10'h005, 32'h0064_0063},  // R3
    {4'd3, 1'b1, 32'h0064_0062, 10'h005, 32'h0064_0003},  // R3
    {4'd3, 1'b1, 32'h0064_0063, 10'h001, 32'h0064_0000},  // R3
    {4'd4, 1'b1, 32'h0064_0003, 10'h3FB, 32'h0064_0062},  // R4
    {4'd4, 1'b1, 32'h0064_0000, 10'h3FF, 32'h0064_0063},  // R4
    {4'd4, 1'b1, 32'h03E8_0064, 10'h200, 32'h03E8_024C},  // R4
    {4'd3, 1'b1, 32'h03E8_0384, 10'h1FF, 32'h03E8_019B},  // R3
    {4'd3, 1'b1, 32'h0006_0002, 10'h004, 32'h0006_0000},  // R3
    {4'd5, 1'b1, 32'h0000_0007, 10'h003, 32'h0000_0007},  // R5
    {4'd5, 1'b1, 32'h0000_0002, 10'h3FB, 32'h0000_0002}   // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 valid in reset", {31'd0, out_valid_o}, 32'd0);
    chk("R8 reg in reset", out_reg_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle valid", {31'd0, out_valid_o}, 32'd0);
    for (int i = 0; i < NV; i++) begin
      mode_i = VEC[i][74]; reg_i = VEC[i][73:42]; step_i = VEC[i][41:32];
      in_valid_i = 1'b1;
      @(negedge clk);
      chk($sformatf("R%0d vec %0d", VEC[i][78:75], i), out_reg_o, VEC[i][31:0]);
      chk($sformatf("R6 upper vec %0d", i), {16'd0, out_reg_o[31:16]}, {16'd0, VEC[i][73:58]});
      chk("R7 valid", {31'd0, out_valid_o}, 32'd1);
    end
    in_valid_i = 1'b0; mode_i = 1'b0; reg_i = 32'h8000_0000;
    @(negedge clk);
    chk("R7 valid drop", {31'd0, out_valid_o}, 32'd0);
    chk("R7 hold", out_reg_o, 32'h0000_0002);
    @(negedge clk);
    chk("R7 hold idle", out_reg_o, 32'h0000_0002);
    in_valid_i = 1'b1; reg_i = 32'h0001_0000;
    @(negedge clk);
    chk("R1 reverse step 0x0001", out_reg_o, 32'h0001_0001);
    chk("R7 valid again", {31'd0, out_valid_o}, 32'd1);
    #1 rst_n = 1'b0;
    #1;
    chk("R8 reset valid", {31'd0, out_valid_o}, 32'd0);
    chk("R8 reset reg", out_reg_o, 32'd0);
    in_valid_i = 1'b0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule